// File: doc/BRIEF.md
# Seconds-and-Fraction Real-Time Counter with Alarm

This block keeps wall-clock time in the low-power domain of a chip. A slow timebase pulse (nominally 32 kHz) advances a 47-bit count. The count is made of a 32-bit whole-seconds word above a 15-bit sub-second fraction. The fraction runs from 0 to 32767 and then carries into the seconds word. The block also holds an alarm value of the same shape. It emits a one-cycle event when counting brings the time onto the alarm.

All register values arrive already synchronised from a companion bridge. The bridge presents a register select and a data word, then pulses a commit strobe. The block decodes the select and loads the named field. The counter starts out frozen and stays frozen, even when enabled, until software has written the seconds field at least once. A separate enable bit in the control field also has to be set before it counts. Because the fraction is loaded on its own, software can zero it first and then load the seconds.

To park the alarm where it will not fire in practice, software writes all ones to the alarm seconds and zero to the alarm fraction.

Top module: `rtc_sec_frac_counter`

## Requirements
- R1: After reset the seconds, fraction, alarm seconds and alarm fraction outputs are 0, the enable output is 0, the never-written flag is 1 and the alarm event is 0.
- R2: While the never-written flag is 1, the count does not change on a timebase pulse, even with the enable bit at 1.
- R3: A commit with select 0 loads the 32-bit data into the seconds word, keeps the fraction, and clears the never-written flag from the next cycle on; the flag never sets again until reset. A commit with select 1 loads data bits 14:0 into the fraction and leaves the flag unchanged.
- R4: A commit with select 4 loads data bit 3 as the enable. The count advances by exactly one fraction unit per timebase pulse only while the enable is 1 and the flag is clear. Cycles without a pulse do not change it.
- R5: The fraction wraps from 32767 to 0 and adds one to the seconds. A full count of seconds 0xFFFFFFFF with fraction 32767 wraps to all zero.
- R6: When a commit to select 0 or 1 falls in the same cycle as a timebase pulse, the written field takes the data and the count does not advance in that cycle.
- R7: When a pulse advances the count onto a value equal to the alarm, the alarm event is 1 for exactly the following cycle. It is not repeated while the values stay equal.
- R8: Making the count and the alarm equal by a commit, with no advance, raises no alarm event.
- R9: Select 2 loads the 32-bit alarm seconds and select 3 loads data bits 14:0 into the alarm fraction, so the parked value 0xFFFFFFFF/0 is held as written. Selects 5 to 7 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-power domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle timebase pulse (32 kHz rate) |
| wr_commit | input | 1 | Commit strobe from the bridge |
| wr_sel | input | 3 | Target field: 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 control |
| wr_data | input | 32 | Data to load |
| sec_q | output | 32 | Whole-seconds count |
| frac_q | output | 15 | Sub-second fraction |
| alarm_sec_q | output | 32 | Alarm seconds |
| alarm_frac_q | output | 15 | Alarm fraction |
| enable_q | output | 1 | Count enable held from the control field |
| unwritten | output | 1 | High until the seconds word is first written |
| alarm_evt | output | 1 | One-cycle alarm-match event |

## Verification
A wrong arming or enable state shows up at the ports one cycle after the next timebase pulse: the count either moves when it should not or stays put. A carry fault is visible only when the fraction crosses 32767, so the bench sets the count to just below that point and also to the full 47-bit boundary. A wrong match decision shows on the event output in the cycle after the advancing pulse. The bench compares every output with a behavioural model on every cycle, so a divergence is flagged at the first cycle it appears.

// File: rtl/rtc_sec_frac_counter.sv
module rtc_sec_frac_counter #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15,
  parameter int DATA_W = 32,
  parameter int EN_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_commit,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEC_W-1:0]  sec_q,
  output logic [FRAC_W-1:0] frac_q,
  output logic [SEC_W-1:0]  alarm_sec_q,
  output logic [FRAC_W-1:0] alarm_frac_q,
  output logic              enable_q,
  output logic              unwritten,
  output logic              alarm_evt
);
  localparam int CNT_W = SEC_W + FRAC_W;
  localparam logic [2:0] SEL_SEC  = 3'd0;
  localparam logic [2:0] SEL_FRAC = 3'd1;
  localparam logic [2:0] SEL_ASEC = 3'd2;
  localparam logic [2:0] SEL_AFRC = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;

  logic [CNT_W-1:0] cnt_q, alarm_q, cnt_inc;
  logic             en_q, unw_q, evt_q;
  logic             time_wr, step;

  assign time_wr = wr_commit && (wr_sel == SEL_SEC || wr_sel == SEL_FRAC);
  assign step    = tick && en_q && !unw_q && !time_wr;
  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alarm_q <= '0;
      en_q    <= 1'b0;
      unw_q   <= 1'b1;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= step && (cnt_inc == alarm_q);
      if (step) cnt_q <= cnt_inc;
      if (wr_commit) begin
        case (wr_sel)
          SEL_SEC: begin
            cnt_q[CNT_W-1:FRAC_W] <= wr_data[SEC_W-1:0];
            unw_q <= 1'b0;
          end
          SEL_FRAC: cnt_q[FRAC_W-1:0]     <= wr_data[FRAC_W-1:0];
          SEL_ASEC: alarm_q[CNT_W-1:FRAC_W] <= wr_data[SEC_W-1:0];
          SEL_AFRC: alarm_q[FRAC_W-1:0]   <= wr_data[FRAC_W-1:0];
          SEL_CTRL: en_q <= wr_data[EN_BIT];
          default: ;
        endcase
      end
    end
  end

  assign sec_q        = cnt_q[CNT_W-1:FRAC_W];
  assign frac_q       = cnt_q[FRAC_W-1:0];
  assign alarm_sec_q  = alarm_q[CNT_W-1:FRAC_W];
  assign alarm_frac_q = alarm_q[FRAC_W-1:0];
  assign enable_q     = en_q;
  assign unwritten    = unw_q;
  assign alarm_evt    = evt_q;

  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (unwritten && !time_wr) |=> ($stable(sec_q) && $stable(frac_q)));

  p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_q && !time_wr) |=> ($stable(sec_q) && $stable(frac_q)));

  p_arm_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !unwritten |=> !unwritten);

  p_arm_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unwritten) |-> $past(wr_commit && wr_sel == SEL_SEC));

  p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_q == '0 && $past(frac_q) == '1 && !$past(time_wr))
      |-> (sec_q == $past(sec_q) + 1'b1));

  p_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_evt && !$past(wr_commit && (wr_sel == SEL_ASEC || wr_sel == SEL_AFRC)))
      |-> (sec_q == alarm_sec_q && frac_q == alarm_frac_q));
endmodule

// File: tb/sim_rtc_sec_frac_counter.sv
module sim_rtc_sec_frac_counter;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned MASK47 = (64'd1 << 47) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_commit = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] sec_q, alarm_sec_q;
  logic [14:0] frac_q, alarm_frac_q;
  logic        enable_q, unwritten, alarm_evt;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  longint unsigned m_cnt = 0, m_alm = 0;
  bit m_en = 0, m_unw = 1, m_evt = 0;

  rtc_sec_frac_counter u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_commit(wr_commit),
    .wr_sel(wr_sel), .wr_data(wr_data), .sec_q(sec_q), .frac_q(frac_q),
    .alarm_sec_q(alarm_sec_q), .alarm_frac_q(alarm_frac_q),
    .enable_q(enable_q), .unwritten(unwritten), .alarm_evt(alarm_evt));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_alm = 0; m_en = 0; m_unw = 1; m_evt = 0;
    end else begin
      bit tw, st;
      longint unsigned nxt;
      tw  = wr_commit && (wr_sel == 3'd0 || wr_sel == 3'd1);
      st  = tick && m_en && !m_unw && !tw;
      nxt = st ? ((m_cnt + 1) & MASK47) : m_cnt;
      m_evt = st && (nxt == m_alm);
      m_cnt = nxt;
      if (wr_commit) begin
        case (wr_sel)
          3'd0: begin m_cnt = (longint'(wr_data) << 15) | (m_cnt & 64'h7FFF); m_unw = 0; end
          3'd1: m_cnt = (m_cnt & ~64'h7FFF) | (wr_data & 32'h7FFF);
          3'd2: m_alm = (longint'(wr_data) << 15) | (m_alm & 64'h7FFF);
          3'd3: m_alm = (m_alm & ~64'h7FFF) | (wr_data & 32'h7FFF);
          3'd4: m_en = wr_data[3];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input longint unsigned act, input longint unsigned exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(sec_q, m_cnt >> 15, "seconds");
    chk(frac_q, m_cnt & 64'h7FFF, "fraction");
    chk(alarm_sec_q, m_alm >> 15, "alarm seconds");
    chk(alarm_frac_q, m_alm & 64'h7FFF, "alarm fraction");
    chk(enable_q, m_en, "enable");
    chk(unwritten, m_unw, "never-written");
    chk(alarm_evt, m_evt, "alarm event");
  endtask

  task automatic cyc(input bit t, input bit c, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    compare_all();
    tick = t; wr_commit = c; wr_sel = s; wr_data = d;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    cyc(1'b0, 1'b1, s, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, 3'd0, 32'd0);
      cyc(1'b0, 1'b0, 3'd0, 32'd0);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    compare_all();
    rst_n = 1'b1;
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);

    cur_req = "R2";
    wr(3'd4, 32'h8);
    ticks(5);

    cur_req = "R3";
    wr(3'd1, 32'hFFFF_8064);
    ticks(3);
    wr(3'd0, 32'd5);
    ticks(2);

    cur_req = "R4";
    ticks(10);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    wr(3'd4, 32'hFFFF_FFF7);
    ticks(4);
    wr(3'd4, 32'h0000_0008);
    cyc(1, 1, 3'd4, 32'h8);
    ticks(2);

    cur_req = "R5";
    wr(3'd0, 32'd7); wr(3'd1, 32'd32766);
    ticks(3);
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'd32767);
    ticks(2);

    cur_req = "R6";
    cyc(1, 1, 3'd0, 32'd40);
    cyc(0, 0, 0, 0);
    cyc(1, 1, 3'd1, 32'd9);
    cyc(0, 0, 0, 0);
    ticks(1);

    cur_req = "R7";
    wr(3'd2, 32'd20); wr(3'd3, 32'd3);
    wr(3'd0, 32'd20); wr(3'd1, 32'd0);
    ticks(6);
    wr(3'd2, 32'd31); wr(3'd3, 32'd0);
    wr(3'd0, 32'd30); wr(3'd1, 32'd32766);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);

    cur_req = "R8";
    wr(3'd0, 32'd31); wr(3'd1, 32'd0);
    cyc(0, 0, 0, 0);
    wr(3'd3, 32'd0);
    wr(3'd2, 32'd31);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);

    cur_req = "R9";
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'd0);
    wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'h1234_5678); wr(3'd7, 32'h0);
    ticks(3);

    cur_req = "R4";
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] s;
      s = 3'($urandom_range(0, 7));
      cyc(1'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0), s,
          (s == 3'd4) ? 32'($urandom_range(0, 15)) : $urandom);
    end
    wr(3'd4, 32'h8);
    wr(3'd0, 32'd100); wr(3'd1, 32'd32760);
    wr(3'd2, 32'd101); wr(3'd3, 32'd2);
    cur_req = "R7";
    for (int i = 0; i < 40; i++) cyc(1'($urandom_range(0, 1)), 0, 0, 0);
    cyc(0, 0, 0, 0);
    finish_run();
  end
endmodule